// File: doc/BRIEF.md
# Dual-Rail Bit Comparison Cell with Completion Detection

This block is one bit-slice of a bit-serial sorting network, written in a self-timed style. It compares an incoming bit pair `a`/`b` under a decision carried in from the more significant slice. It then emits the smaller-number bit on one output and the larger-number bit on the other, together with the decision for the next slice. Every data and decision signal, in and out, is a dual-rail pair. Each output pair rests in an all-ones spacer between operations. During an operation it resolves to exactly one valid code by letting a single rail fall.

The cell has two alternating phases. A rising `start_i` launches an evaluation that samples the inputs. A falling `start_i` returns every output pair to the spacer. The cell does not time its completion flag with a matched delay. `ready_o` is decoded from the output rails themselves and rises only once every pair has resolved. In the register-level model each output pair resolves after a pseudo-random number of clock edges, from 1 to `LAT_MAX`. The completion logic is therefore exercised against skewed arrival of the outputs.

Top module: `dr_cmp_cell`

## Requirements
- R1: After reset, every output pair holds the spacer 2'b11 and `ready_o` is 0.
- R2: Each pair is two bits. 2'b11 is the spacer, logical 1 is 2'b10 (bit 0 low) and logical 0 is 2'b01 (bit 1 low). An output pair never shows 2'b00. Once a pair leaves the spacer during an evaluation, it keeps its value until the cell returns to precharge.
- R3: `ready_o` is 1 exactly when all four output pairs hold complementary rails. It is 0 whenever any output pair is in the spacer, and therefore throughout precharge.
- R4: The clock edge that first sees `start_i` high after it was low samples all inputs. Each output pair resolves on that edge or on one of the following edges, at most `LAT_MAX` edges counting the sampling edge. With `LAT_MAX` = 1, all pairs are valid right after the sampling edge.
- R5: The first clock edge that sees `start_i` low after an evaluation returns all output pairs to the spacer and drops `ready_o`, whether or not the evaluation had finished.
- R6: With the incoming decision undecided (swap flag 0, pass flag 0) and `a` equal to `b`, the decision out is undecided (0,0), `lo_o` = `a` and `hi_o` = `b`.
- R7: With the incoming decision undecided and `a` different from `b`, the cell decides. For `a`=0, `b`=1 the decision out is pass (swap 0, pass 1) and the bits go straight through. For `a`=1, `b`=0 it is swap (swap 1, pass 0) and the bits cross. In both cases `lo_o` carries 0 and `hi_o` carries 1.
- R8: An incoming decision of swap (1,0) or pass (0,1) is forwarded unchanged. Swap gives `lo_o` = `b` and `hi_o` = `a`. Pass gives `lo_o` = `a` and `hi_o` = `b`.
- R9: The illegal incoming decision (1,1) is forwarded as (1,1) and steers the bits as a swap.
- R10: Changes on the data and decision inputs after the sampling edge have no effect on the outputs of the evaluation in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start_i | input | 1 | Phase control: rising edge launches evaluation, low means precharge |
| a_i | input | 2 | Dual-rail first data bit |
| b_i | input | 2 | Dual-rail second data bit |
| dsw_i | input | 2 | Dual-rail incoming swap flag |
| dps_i | input | 2 | Dual-rail incoming pass flag |
| lo_o | output | 2 | Dual-rail bit belonging to the smaller number |
| hi_o | output | 2 | Dual-rail bit belonging to the larger number |
| dsw_o | output | 2 | Dual-rail outgoing swap flag |
| dps_o | output | 2 | Dual-rail outgoing pass flag |
| ready_o | output | 1 | Completion: all output pairs valid |

## Verification
The hardest situation to reach from the ports is a partly resolved evaluation. In that state some output pairs are valid while others are still in the spacer, and `ready_o` must remain low. The bench uses a cell whose latencies vary pseudo-randomly up to four edges. It polls every cycle of every evaluation, checking each pair against its expected code or the spacer and `ready_o` against the rails it sees. A second instance with a fixed one-edge latency pins the exact timing. Early aborts and input scrambling after the sampling edge cover the precharge and hold rules.

// File: rtl/dr_pkg.sv
package dr_pkg;
    typedef logic [1:0] rail_t;

    localparam rail_t SPACER = 2'b11;

    // logical 1 drops bit 0, logical 0 drops bit 1
    function automatic rail_t enc(input logic v);
        return v ? 2'b10 : 2'b01;
    endfunction

    function automatic logic dec(input rail_t p);
        return ~p[0];
    endfunction
endpackage

// File: rtl/dr_lfsr.sv
module dr_lfsr #(
    parameter int              W    = 16,
    parameter logic [W-1:0]    TAPS = 16'hB400,
    parameter logic [W-1:0]    SEED = 16'hACE1
) (
    input  logic         clk,
    input  logic         rst,
    output logic [W-1:0] q_o
);
    typedef struct packed {
        logic [W-1:0] sr;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (st_q.sr[0]) st_d.sr = (st_q.sr >> 1) ^ TAPS;
        else            st_d.sr = st_q.sr >> 1;
    end

    always_ff @(posedge clk) begin
        if (rst) st_q.sr <= SEED;
        else     st_q    <= st_d;
    end

    assign q_o = st_q.sr;

    AST_LFSR_NONZERO: assert property (@(posedge clk) disable iff (rst)
        st_q.sr != '0);  // R4
endmodule

// File: rtl/dr_cmp_logic.sv
module dr_cmp_logic (
    input  logic a_i,
    input  logic b_i,
    input  logic sw_i,
    input  logic ps_i,
    output logic lo_o,
    output logic hi_o,
    output logic sw_o,
    output logic ps_o
);
    logic open_d;
    logic cross_d;

    always_comb begin
        open_d = ~sw_i & ~ps_i;
        if (open_d) begin
            sw_o    = a_i & ~b_i;
            ps_o    = ~a_i & b_i;
            cross_d = a_i & ~b_i;
        end else begin
            sw_o    = sw_i;
            ps_o    = ps_i;
            cross_d = sw_i;
        end
        lo_o = cross_d ? b_i : a_i;
        hi_o = cross_d ? a_i : b_i;
    end
endmodule

// File: rtl/dr_rail_out.sv
module dr_rail_out
    import dr_pkg::*;
#(
    parameter int LAT_MAX = 4,
    parameter int LW      = $clog2(LAT_MAX + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          launch_i,
    input  logic          drop_i,
    input  logic [LW-1:0] lat_i,
    input  logic          val_i,
    output rail_t         rail_o
);
    typedef struct packed {
        logic [LW-1:0] cnt;
        rail_t         rail;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (launch_i) begin
            st_d.cnt  = lat_i - LW'(1);
            st_d.rail = (lat_i == LW'(1)) ? enc(val_i) : SPACER;
        end else if (drop_i) begin
            st_d.cnt  = '0;
            st_d.rail = SPACER;
        end else if (st_q.cnt != '0) begin
            st_d.cnt = st_q.cnt - LW'(1);
            if (st_q.cnt == LW'(1)) st_d.rail = enc(val_i);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q.cnt  <= '0;
            st_q.rail <= SPACER;
        end else begin
            st_q <= st_d;
        end
    end

    assign rail_o = st_q.rail;

    AST_NO_NULL_PAIR: assert property (@(posedge clk) disable iff (rst)
        st_q.rail != 2'b00);  // R2
    AST_HOLD_RESOLVED: assert property (@(posedge clk) disable iff (rst)
        (st_q.rail != SPACER && !drop_i) |=> st_q.rail == $past(st_q.rail));  // R2
    AST_LAT_BOUND: assert property (@(posedge clk) disable iff (rst)
        st_q.cnt < LW'(LAT_MAX));  // R4
endmodule

// File: rtl/dr_cmp_cell.sv
module dr_cmp_cell
    import dr_pkg::*;
#(
    parameter int          LAT_MAX = 4,
    parameter int          LFSR_W  = 16,
    parameter logic [15:0] SEED    = 16'hACE1
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       start_i,
    input  logic [1:0] a_i,
    input  logic [1:0] b_i,
    input  logic [1:0] dsw_i,
    input  logic [1:0] dps_i,
    output logic [1:0] lo_o,
    output logic [1:0] hi_o,
    output logic [1:0] dsw_o,
    output logic [1:0] dps_o,
    output logic       ready_o
);
    localparam int NPAIR = 4;
    localparam int SLW   = LFSR_W / NPAIR;
    localparam int LW    = $clog2(LAT_MAX + 1);

    typedef struct packed {
        logic start;
        logic a;
        logic b;
        logic sw;
        logic ps;
    } st_t;

    st_t st_d, st_q;
    logic launch, drop;
    logic op_a, op_b, op_sw, op_ps;
    logic [NPAIR-1:0] res;
    logic [NPAIR-1:0] pair_ok;
    logic [LFSR_W-1:0] rnd;
    logic [LW-1:0] lat [NPAIR];
    rail_t rails [NPAIR];

    always_comb begin
        st_d       = st_q;
        launch     = start_i & ~st_q.start;
        drop       = ~start_i & st_q.start;
        st_d.start = start_i;
        if (launch) begin
            st_d.a  = dec(a_i);
            st_d.b  = dec(b_i);
            st_d.sw = dec(dsw_i);
            st_d.ps = dec(dps_i);
        end
        // the sampling edge sees live inputs, later edges the held copy
        op_a  = launch ? dec(a_i)   : st_q.a;
        op_b  = launch ? dec(b_i)   : st_q.b;
        op_sw = launch ? dec(dsw_i) : st_q.sw;
        op_ps = launch ? dec(dps_i) : st_q.ps;
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    dr_lfsr #(.W(LFSR_W), .TAPS(16'hB400), .SEED(SEED)) lfsr_i (
        .clk (clk),
        .rst (rst),
        .q_o (rnd)
    );

    dr_cmp_logic cmp_i (
        .a_i  (op_a),
        .b_i  (op_b),
        .sw_i (op_sw),
        .ps_i (op_ps),
        .lo_o (res[0]),
        .hi_o (res[1]),
        .sw_o (res[2]),
        .ps_o (res[3])
    );

    for (genvar g = 0; g < NPAIR; g++) begin : g_pair
        assign lat[g] = LW'(1 + (int'(rnd[SLW*g +: SLW]) % LAT_MAX));

        dr_rail_out #(.LAT_MAX(LAT_MAX), .LW(LW)) out_i (
            .clk      (clk),
            .rst      (rst),
            .launch_i (launch),
            .drop_i   (drop),
            .lat_i    (lat[g]),
            .val_i    (res[g]),
            .rail_o   (rails[g])
        );

        assign pair_ok[g] = rails[g][1] ^ rails[g][0];
    end

    assign lo_o    = rails[0];
    assign hi_o    = rails[1];
    assign dsw_o   = rails[2];
    assign dps_o   = rails[3];
    assign ready_o = &pair_ok;

    AST_NO_READY_PRECHARGE: assert property (@(posedge clk) disable iff (rst)
        !st_q.start |-> !ready_o);  // R3
    AST_READY_RISES_IN_EVAL: assert property (@(posedge clk) disable iff (rst)
        $rose(ready_o) |-> st_q.start);  // R4
    AST_DROP_CLEARS: assert property (@(posedge clk) disable iff (rst)
        drop |=> (lo_o == SPACER && hi_o == SPACER && dsw_o == SPACER && dps_o == SPACER));  // R5
endmodule

// File: tb/dr_cmp_cell_tb.sv
module dr_cmp_cell_tb_top;
    localparam int LAT_R = 4;

    // {a, b, sw, ps, lo, hi, sw_out, ps_out}
    localparam logic [7:0] VEC [16] = '{
        8'b0000_0000, 8'b0001_0001, 8'b0010_0010, 8'b0011_0011,
        8'b0100_0101, 8'b0101_0101, 8'b0110_1010, 8'b0111_1011,
        8'b1000_0110, 8'b1001_1001, 8'b1010_0110, 8'b1011_0111,
        8'b1100_1100, 8'b1101_1101, 8'b1110_1110, 8'b1111_1111
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start = 1'b0;
    logic [1:0] a = 2'b11, b = 2'b11, dsw = 2'b11, dps = 2'b11;
    logic [1:0] lo_r, hi_r, sw_r, ps_r, lo_f, hi_f, sw_f, ps_f;
    logic rdy_r, rdy_f;
    int checks = 0;
    int fails  = 0;
    bit done_all = 0;

    always #2.5 clk = ~clk;

    dr_cmp_cell #(.LAT_MAX(LAT_R), .SEED(16'hACE1)) dut_i (
        .clk(clk), .rst(rst), .start_i(start),
        .a_i(a), .b_i(b), .dsw_i(dsw), .dps_i(dps),
        .lo_o(lo_r), .hi_o(hi_r), .dsw_o(sw_r), .dps_o(ps_r), .ready_o(rdy_r)
    );

    dr_cmp_cell #(.LAT_MAX(1), .SEED(16'h1D2B)) dut_fix (
        .clk(clk), .rst(rst), .start_i(start),
        .a_i(a), .b_i(b), .dsw_i(dsw), .dps_i(dps),
        .lo_o(lo_f), .hi_o(hi_f), .dsw_o(sw_f), .dps_o(ps_f), .ready_o(rdy_f)
    );

    function automatic logic [1:0] enc(input logic v);
        return v ? 2'b10 : 2'b01;
    endfunction

    function automatic logic [7:0] pack4(input logic [3:0] v);
        return {enc(v[3]), enc(v[2]), enc(v[1]), enc(v[0])};
    endfunction

    function automatic string tag_of(input logic [7:0] v);
        if (v[5] && v[4])      return "R9";
        else if (v[5] || v[4]) return "R8";
        else if (v[7] == v[6]) return "R6";
        else                   return "R7";
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic drive(input logic [3:0] v);
        a = enc(v[3]); b = enc(v[2]); dsw = enc(v[1]); dps = enc(v[0]);
    endtask

    task automatic check_spacer(input string req);
        chk({lo_r, hi_r, sw_r, ps_r} == 8'hFF && !rdy_r, req, "random cell not precharged",
            {rdy_r, lo_r, hi_r, sw_r, ps_r}, 9'h0FF);
        chk({lo_f, hi_f, sw_f, ps_f} == 8'hFF && !rdy_f, req, "fixed cell not precharged",
            {rdy_f, lo_f, hi_f, sw_f, ps_f}, 9'h0FF);
    endtask

    task automatic run_vec(input int idx, input bit scramble);
        logic [7:0] v;
        logic [7:0] exp_rails;
        logic [7:0] got;
        int n;
        bit seen;
        v = VEC[idx];
        exp_rails = pack4(v[3:0]);
        @(negedge clk);
        drive(v[7:4]);
        start = 1'b1;
        n = 0;
        seen = 0;
        while (!seen && n <= LAT_R) begin
            @(negedge clk);
            n++;
            if (n == 1) begin
                got = {lo_f, hi_f, sw_f, ps_f};
                chk(rdy_f == 1'b1, "R4", "fixed cell not ready after one edge", rdy_f, 1);
                chk(got == exp_rails, tag_of(v), "fixed cell outputs", got, exp_rails);
                if (scramble) drive(~v[7:4]);
            end
            got = {lo_r, hi_r, sw_r, ps_r};
            for (int p = 0; p < 4; p++) begin
                chk(got[2*p +: 2] == 2'b11 || got[2*p +: 2] == exp_rails[2*p +: 2],
                    "R2", "pair neither spacer nor expected code", got[2*p +: 2],
                    exp_rails[2*p +: 2]);
            end
            chk(rdy_r == (got[7:6] != 2'b11 && got[5:4] != 2'b11 &&
                          got[3:2] != 2'b11 && got[1:0] != 2'b11),
                "R3", "ready disagrees with rails", rdy_r, !rdy_r);
            seen = rdy_r;
        end
        chk(seen && n <= LAT_R, "R4", "random cell latency", n, LAT_R);
        got = {lo_r, hi_r, sw_r, ps_r};
        chk(got == exp_rails, tag_of(v), "random cell outputs", got, exp_rails);
        @(negedge clk);
        got = {lo_f, hi_f, sw_f, ps_f};
        chk(got == exp_rails && rdy_f, scramble ? "R10" : "R2", "fixed cell held value",
            got, exp_rails);
        start = 1'b0;
        @(negedge clk);
        check_spacer("R5");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check_spacer("R1");
        rst = 1'b0;
        @(negedge clk);
        check_spacer("R1");

        for (int pass = 0; pass < 3; pass++) begin
            for (int i = 0; i < 16; i++) begin
                run_vec(i, pass == 2);
            end
        end

        // R5: abort right after launch, then a clean evaluation must follow
        for (int k = 0; k < 6; k++) begin
            @(negedge clk);
            drive(4'b1000);
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
            @(negedge clk);
            check_spacer("R5");
            @(negedge clk);
            check_spacer("R3");
        end
        run_vec(8, 1'b0);

        // R10: holding start high with new inputs starts nothing new
        @(negedge clk);
        drive(4'b0100);
        start = 1'b1;
        repeat (LAT_R + 1) @(negedge clk);
        drive(4'b1000);
        repeat (3) @(negedge clk);
        chk({lo_r, hi_r, sw_r, ps_r} == pack4(4'b0101) && rdy_r, "R10",
            "held evaluation changed", {lo_r, hi_r, sw_r, ps_r}, pack4(4'b0101));
        start = 1'b0;
        @(negedge clk);
        check_spacer("R5");

        // R1: reset in the middle of an evaluation
        @(negedge clk);
        drive(4'b1111);
        start = 1'b1;
        @(negedge clk);
        rst = 1'b1;
        start = 1'b0;
        @(negedge clk);
        check_spacer("R1");
        rst = 1'b0;

        done_all = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done_all) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule